// File: doc/BRIEF.md
# Timer Output Compare Unit

This block is a single output-compare channel. It holds a 16-bit compare value. On every clock it tests that value against the count of one of two free-running 16-bit timers; a select input picks the timer. The first cycle of equality is a match. A match raises a sticky interrupt flag. It also acts on a held output level: the level is set, cleared, toggled or left alone, as a 4-bit mode field chooses. The held level reaches the pin only while the output-enable input allows it. An interrupt-enable input qualifies the interrupt line.

The mode field is decoded into a small state machine with five states. S_OFF is the disabled state. S_SET sets the level on a match. S_CLR clears it. S_TGL inverts it. S_SWI raises the flag only. A mode write is the only transition. Writing 4'b0000 or any unlisted code moves to S_OFF and clears the level. Writing 4'b1000 from S_OFF initialises the level low, and writing 4'b1001 from S_OFF initialises it high. Every other write changes the state and leaves the level as it is.

Top module: `ocu_top`

## Requirements
- R1: A match is the first cycle in which the selected timer equals the stored compare value. `src_sel`=0 selects `tmr_a` and 1 selects `tmr_b`. A `wr_val` pulse loads `wr_data` as the compare value, and the new value applies from the next cycle.
- R2: In mode 4'b1000, a match sets the held level high at the clock edge that closes the match cycle.
- R3: In mode 4'b1001, a match clears the held level low at that same edge.
- R4: In mode 4'b0010, each match inverts the held level.
- R5: A match in any active mode (4'b1000, 4'b1001, 4'b0010, 4'b1010) sets `flag_o` at the same edge as the pin action. The flag then stays set until `flag_clr` is pulsed. When a clear and a match fall in the same cycle, the flag ends set.
- R6: In mode 4'b1010, a match leaves the held level unchanged and only sets the flag. `irq_o` is high exactly when `flag_o` and `irq_en` are both high.
- R7: Equality that persists for several cycles counts as one match. It gives one pin action and one flag set.
- R8: Writing mode 4'b0000 clears the held level at the next edge. In 4'b0000 or any unlisted code, matches set no flag and do not move the level.
- R9: Writing 4'b1000 from a disabled mode makes the level low, and writing 4'b1001 from a disabled mode makes it high. A mode write outranks a match in the same cycle for the level. The flag in that cycle follows the old mode.
- R10: `pin_en` follows `out_en`. `pin_o` carries the held level when `out_en` is 1 and is 0 otherwise.
- R11: After reset the level is low, the flag is clear, the mode is disabled and the compare value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| wr_val | input | 1 | load compare value |
| wr_data | input | 16 | compare value to load |
| wr_mode | input | 1 | load mode field |
| mode_in | input | 4 | mode field to load |
| tmr_a | input | 16 | timer count, source 0 |
| tmr_b | input | 16 | timer count, source 1 |
| src_sel | input | 1 | timer source select |
| out_en | input | 1 | pin driver enable |
| irq_en | input | 1 | interrupt enable |
| flag_clr | input | 1 | clear interrupt flag |
| pin_o | output | 1 | compare output level |
| pin_en | output | 1 | pin driver active |
| flag_o | output | 1 | interrupt flag |
| irq_o | output | 1 | qualified interrupt |

## Verification
Two pairs of events can land in one cycle: a flag clear with a new match, and a mode write with a match. The bench provokes both with directed stimulus. It places the clear, or the write, in the exact cycle in which the selected timer first reaches the compare value. The outcome is judged against a behavioural model that rebuilds the flag and the level from the requirements alone. A long run follows with pseudo-random timers, modes and clears over a narrow value range, so that these coincidences recur; the model is compared on every clock.

// File: rtl/ocu_pkg.sv
package ocu_pkg;
    localparam int MODE_W = 4;

    typedef enum logic [2:0] {
        S_OFF,
        S_SET,
        S_CLR,
        S_TGL,
        S_SWI
    } ocu_st_e;

    localparam logic [MODE_W-1:0] M_OFF = 4'b0000;
    localparam logic [MODE_W-1:0] M_SET = 4'b1000;
    localparam logic [MODE_W-1:0] M_CLR = 4'b1001;
    localparam logic [MODE_W-1:0] M_TGL = 4'b0010;
    localparam logic [MODE_W-1:0] M_SWI = 4'b1010;

    function automatic ocu_st_e decode_mode(input logic [MODE_W-1:0] m);
        ocu_st_e s;
        case (m)
            M_SET:   s = S_SET;
            M_CLR:   s = S_CLR;
            M_TGL:   s = S_TGL;
            M_SWI:   s = S_SWI;
            default: s = S_OFF;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/ocu_match.sv
module ocu_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_val,
    input  logic [W-1:0] wr_data,
    input  logic [W-1:0] tmr_a,
    input  logic [W-1:0] tmr_b,
    input  logic         src_sel,
    output logic         hit
);
    logic [W-1:0] cmp_q;
    logic [W-1:0] cnt_sel;
    logic         eq_now;
    logic         eq_q;

    assign cnt_sel = src_sel ? tmr_b : tmr_a;
    assign eq_now  = (cnt_sel == cmp_q);
    assign hit     = eq_now && !eq_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            eq_q  <= 1'b0;
        end else begin
            eq_q <= eq_now;
            if (wr_val) cmp_q <= wr_data;
        end
    end

    // R7: a match never repeats on the following cycle
    p_one_shot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit);
endmodule

// File: rtl/ocu_ctrl.sv
module ocu_ctrl
    import ocu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_mode,
    input  logic [MODE_W-1:0] mode_in,
    input  logic              hit,
    output logic              level,
    output logic              act
);
    ocu_st_e st_q;
    ocu_st_e st_nx;
    logic    level_nx;

    assign act = hit && (st_q != S_OFF);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_OFF;
        else        st_q <= st_nx;
    end

    always_comb begin
        st_nx = st_q;
        if (wr_mode) st_nx = decode_mode(mode_in);
    end

    // output level
    always_comb begin
        level_nx = level;
        if (wr_mode) begin
            unique case (decode_mode(mode_in))
                S_OFF:   level_nx = 1'b0;
                S_SET:   if (st_q == S_OFF) level_nx = 1'b0;
                S_CLR:   if (st_q == S_OFF) level_nx = 1'b1;
                S_TGL:   level_nx = level;
                S_SWI:   level_nx = level;
            endcase
        end else if (hit) begin
            unique case (st_q)
                S_OFF:   level_nx = level;
                S_SET:   level_nx = 1'b1;
                S_CLR:   level_nx = 1'b0;
                S_TGL:   level_nx = !level;
                S_SWI:   level_nx = level;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level <= 1'b0;
        else        level <= level_nx;
    end

    p_set_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SET && hit && !wr_mode) |=> level);
    p_clr_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_CLR && hit && !wr_mode) |=> !level);
    p_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_TGL && hit && !wr_mode) |=> (level != $past(level)));
    p_swi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_SWI && !wr_mode) |=> $stable(level));
    p_off_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && mode_in == M_OFF) |=> !level);
    p_init_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && mode_in == M_CLR && st_q == S_OFF) |=> level);
endmodule

// File: rtl/ocu_flag.sv
module ocu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic act,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   flag <= 1'b0;
        else if (act) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    p_flag_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> flag);
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !act && !clr) |=> flag);
endmodule

// File: rtl/ocu_top.sv
module ocu_top
    import ocu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_val,
    input  logic [W-1:0]      wr_data,
    input  logic              wr_mode,
    input  logic [MODE_W-1:0] mode_in,
    input  logic [W-1:0]      tmr_a,
    input  logic [W-1:0]      tmr_b,
    input  logic              src_sel,
    input  logic              out_en,
    input  logic              irq_en,
    input  logic              flag_clr,
    output logic              pin_o,
    output logic              pin_en,
    output logic              flag_o,
    output logic              irq_o
);
    logic hit;
    logic act;
    logic level;

    ocu_match #(.W(W)) u_match (
        .clk(clk), .rst_n(rst_n), .wr_val(wr_val), .wr_data(wr_data),
        .tmr_a(tmr_a), .tmr_b(tmr_b), .src_sel(src_sel), .hit(hit)
    );

    ocu_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_mode(wr_mode), .mode_in(mode_in),
        .hit(hit), .level(level), .act(act)
    );

    ocu_flag u_flag (
        .clk(clk), .rst_n(rst_n), .act(act), .clr(flag_clr), .flag(flag_o)
    );

    assign pin_en = out_en;
    assign pin_o  = out_en & level;
    assign irq_o  = flag_o & irq_en;

    // R5: a qualified match is always followed by a raised interrupt when enabled
    p_irq_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (act && irq_en) |=> (flag_o && (irq_o || !irq_en)));
endmodule

// File: tb/sim_ocu_top.sv
module sim_ocu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_val = 1'b0;
    logic [15:0] wr_data = '0;
    logic        wr_mode = 1'b0;
    logic [3:0]  mode_in = '0;
    logic [15:0] tmr_a = 16'h0100;
    logic [15:0] tmr_b = 16'h0100;
    logic        src_sel = 1'b0;
    logic        out_en = 1'b1;
    logic        irq_en = 1'b0;
    logic        flag_clr = 1'b0;
    logic        pin_o, pin_en, flag_o, irq_o;

    int checks = 0;
    int bad = 0;

    always #2 clk = ~clk;

    ocu_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_val(wr_val), .wr_data(wr_data),
        .wr_mode(wr_mode), .mode_in(mode_in), .tmr_a(tmr_a), .tmr_b(tmr_b),
        .src_sel(src_sel), .out_en(out_en), .irq_en(irq_en),
        .flag_clr(flag_clr), .pin_o(pin_o), .pin_en(pin_en),
        .flag_o(flag_o), .irq_o(irq_o)
    );

    // behavioural reference
    logic [15:0] m_cmp = '0;
    logic [3:0]  m_mode = '0;
    bit          m_prev = 0;
    bit          m_lvl = 0;
    bit          m_flag = 0;

    function automatic bit is_active(input logic [3:0] m);
        return (m == 4'b1000) || (m == 4'b1001) || (m == 4'b0010) || (m == 4'b1010);
    endfunction

    task automatic chk(input string req, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act_v, exp_v, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cmp = '0; m_mode = '0; m_prev = 0; m_lvl = 0; m_flag = 0;
        end else begin
            bit eq, act;
            eq  = ((src_sel ? tmr_b : tmr_a) == m_cmp);
            act = eq && !m_prev && is_active(m_mode);
            if (act) m_flag = 1;
            else if (flag_clr) m_flag = 0;
            if (wr_mode) begin
                if (!is_active(mode_in)) m_lvl = 0;
                else if (!is_active(m_mode) && mode_in == 4'b1000) m_lvl = 0;
                else if (!is_active(m_mode) && mode_in == 4'b1001) m_lvl = 1;
            end else if (act) begin
                case (m_mode)
                    4'b1000: m_lvl = 1;
                    4'b1001: m_lvl = 0;
                    4'b0010: m_lvl = !m_lvl;
                    default: ;
                endcase
            end
            m_prev = eq;
            if (wr_val) m_cmp = wr_data;
            if (wr_mode) m_mode = mode_in;
        end
        #1;
        chk("R2/R3/R4 pin level", int'(pin_o), int'(out_en & m_lvl));
        chk("R10 pin_en", int'(pin_en), int'(out_en));
        chk("R5 flag", int'(flag_o), int'(m_flag));
        chk("R6 irq", int'(irq_o), int'(m_flag & irq_en));
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_mode(input logic [3:0] m);
        wr_mode = 1; mode_in = m; step(); wr_mode = 0;
    endtask

    bit done = 0;
    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; checks++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        chk("R11 reset pin", int'(pin_o), 0);
        chk("R11 reset flag", int'(flag_o), 0);
        rst_n = 1;
        step();
        // R1 load compare value, R9 init low for set mode
        wr_val = 1; wr_data = 16'h0040; step(); wr_val = 0;
        set_mode(4'b1000);
        chk("R9 init low", int'(pin_o), 0);
        tmr_a = 16'h003f; step();
        chk("R1 no match yet", int'(flag_o), 0);
        tmr_a = 16'h0040; step();
        chk("R2 set high", int'(pin_o), 1);
        chk("R5 flag set", int'(flag_o), 1);
        flag_clr = 1; step(); flag_clr = 0;
        step(3);
        chk("R7 persistent equality once", int'(flag_o), 0);
        // R3 clear mode, active->active keeps level
        set_mode(4'b1001);
        chk("R9 keep level", int'(pin_o), 1);
        tmr_a = 0; step();
        src_sel = 1; tmr_b = 16'h0040; step();
        chk("R1 timer b match", int'(flag_o), 1);
        chk("R3 clear low", int'(pin_o), 0);
        flag_clr = 1; step(); flag_clr = 0;
        // R4 toggle
        set_mode(4'b0010);
        tmr_b = 0; step(); tmr_b = 16'h0040; step();
        chk("R4 toggle 1", int'(pin_o), 1);
        tmr_b = 0; step(); tmr_b = 16'h0040; step();
        chk("R4 toggle 2", int'(pin_o), 0);
        // R6 software interrupt mode
        tmr_b = 0; step(); set_mode(4'b1001);
        set_mode(4'b0000); set_mode(4'b1001);
        chk("R9 init high", int'(pin_o), 1);
        set_mode(4'b1010);
        flag_clr = 1; step(); flag_clr = 0;
        irq_en = 0; tmr_b = 16'h0040; step();
        chk("R6 pin unchanged", int'(pin_o), 1);
        chk("R6 irq masked", int'(irq_o), 0);
        irq_en = 1; step();
        chk("R6 irq raised", int'(irq_o), 1);
        // R5 clear coincident with match
        tmr_b = 0; step();
        flag_clr = 1; tmr_b = 16'h0040; step(); flag_clr = 0;
        chk("R5 clear+match keeps flag", int'(flag_o), 1);
        // R8 disable clears level, unlisted mode ignores match
        set_mode(4'b0000);
        chk("R8 off low", int'(pin_o), 0);
        set_mode(4'b0101);
        flag_clr = 1; step(); flag_clr = 0;
        tmr_b = 0; step(); tmr_b = 16'h0040; step();
        chk("R8 no flag when off", int'(flag_o), 0);
        // R9 mode write coincident with match
        set_mode(4'b1000);
        tmr_b = 0; step();
        tmr_b = 16'h0040; wr_mode = 1; mode_in = 4'b0000; step(); wr_mode = 0;
        chk("R9 write outranks match", int'(pin_o), 0);
        chk("R9 flag from old mode", int'(flag_o), 1);
        // R10 driver disable
        set_mode(4'b1001);
        out_en = 0; step();
        chk("R10 pin gated", int'(pin_o), 0);
        chk("R10 pin_en low", int'(pin_en), 0);
        out_en = 1; step();
        chk("R10 pin restored", int'(pin_o), 1);
        // pseudo-random run compared against the model every clock
        begin
            logic [15:0] lf = 16'hace1;
            for (int i = 0; i < 3000; i++) begin
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                tmr_a    = {14'd0, lf[1:0]};
                tmr_b    = {14'd0, lf[3:2]};
                src_sel  = lf[4];
                flag_clr = (lf[7:5] == 3'd0);
                irq_en   = lf[8];
                out_en   = (lf[11:9] != 3'd0);
                wr_val   = (lf[14:12] == 3'd0);
                wr_data  = {14'd0, lf[6:5]};
                wr_mode  = (lf[15:13] == 3'd7);
                case (lf[2:0])
                    3'd0: mode_in = 4'b0000;
                    3'd1: mode_in = 4'b1000;
                    3'd2: mode_in = 4'b1001;
                    3'd3: mode_in = 4'b0010;
                    3'd4: mode_in = 4'b1010;
                    3'd5: mode_in = 4'b0111;
                    default: mode_in = 4'b1000;
                endcase
                step();
            end
        end
        wr_val = 0; wr_mode = 0; flag_clr = 0;
        step(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule